// File: doc/BRIEF.md
# Dual-Bank Transmit Buffer Controller

This block is the transmit side of a small Ethernet MAC. Software fills two independent packet banks through a 32-bit, word-addressed register port. Each bank has a length register and a command register. A write to a command register either streams the bank's bytes out over a valid/ready byte stream, or copies the first six bytes of the bank into a 48-bit station address register.

When a command finishes, the block can raise a one-cycle interrupt pulse. The pulse needs both the per-bank enable and a single global enable. While a bank's command is queued or running, its command bits read back as set, and they clear by themselves when the command completes. A start on one bank while the other bank is busy waits its turn. A command written to a bank that is already busy is dropped.

Top module: `txbank_ctrl`

## Requirements
- R1: After reset the stream valid is 0, the interrupt is 0, the station address is 0, and the length, command and global-enable registers read 0.
- R2: Word addresses (default 512 words per bank) map as follows. Bank 0 data is at 0x000-0x1FC, its length at 0x1FD, the global enable at 0x1FE and its command at 0x1FF. Bank 1 data is at 0x200-0x3FC, its length at 0x3FD and its command at 0x3FF. A read returns its data on `reg_rdata` in the cycle after `reg_rd`. Data words read back as written. Length reads back its low 16 bits, and the global enable reads back bit 31 only.
- R3: A command write with bit 0 = 1 and bit 1 = 0 streams the bank's length in bytes, starting at the bank base. Within each word, bits 7:0 go first and bits 31:24 go last. `tx_tlast` is high only on the final byte.
- R4: A command write with bit 0 = 1 and bit 1 = 1 loads the station address from the bank's first six bytes. Byte 0 lands in bits 47:40 and byte 5 lands in bits 7:0. No bytes are streamed.
- R5: Command bits 1:0 read back as written while the command is queued or running, and they clear on completion. Bits 31:2 always hold the last written value.
- R6: A command write with bit 0 = 0 starts nothing and stores bits 31:2, with bits 1:0 reading 0.
- R7: A command write to a bank whose bit 0 is already set updates bits 31:2 only. Its command bits are ignored.
- R8: A start written to one bank while the other bank is transmitting is held. It runs right after the current command, including when the start is written in the very cycle the current command completes.
- R9: On completion, `irq` pulses high for exactly one cycle only if command bit 3 of that bank and global-enable bit 31 are both set.
- R10: A length of 0 completes with no bytes streamed. A length above 2036 is treated as 2036.
- R11: While `tx_tvalid` is high and `tx_tready` is low, the byte and last flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register/buffer write strobe |
| reg_rd | input | 1 | Register/buffer read strobe |
| reg_addr | input | 10 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_tvalid | output | 1 | Frame byte valid |
| tx_tready | input | 1 | Downstream accepts a byte |
| tx_tdata | output | 8 | Frame byte |
| tx_tlast | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Station MAC address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Two functions can coincide in one cycle. One bank's completion clears its command bits and decides the interrupt, and in that same cycle a start can be written to the other bank's command register. The bench provokes this by watching for the final byte handshake of bank 0 and issuing the bank 1 start on the next clock. That clock is the one on which bank 0's completion registers. The result is judged by the bank 1 frame following directly, by exactly two interrupt pulses, and by both command registers reading back with cleared command bits.

// File: rtl/txbank_pkg.sv
package txbank_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_SEND,
    ENG_PA0,
    ENG_PA1,
    ENG_PA2,
    ENG_FIN
  } eng_state_t;

  localparam int unsigned CMD_GO   = 0;
  localparam int unsigned CMD_PROG = 1;
  localparam int unsigned CMD_IE   = 3;
  localparam int unsigned GEN_BIT  = 31;
  localparam int unsigned LREG_W   = 16;
endpackage

// File: rtl/txbank_mem.sv
module txbank_mem #(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  output logic [31:0]   a_q,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  output logic [31:0]   b_q
);
  logic [31:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (a_re) a_q <= store[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_re) b_q <= store[b_addr];
  end
endmodule

// File: rtl/txbank_regs.sv
module txbank_regs
  import txbank_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_len,
  input  logic                   wr_gen,
  input  logic                   wr_cmd,
  input  logic                   wr_bank,
  input  logic [31:0]            wdata,
  input  logic                   done,
  input  logic                   done_bank,
  output logic [1:0][LREG_W-1:0] len_q,
  output logic [1:0][31:0]       cmd_q,
  output logic                   gen_q,
  output logic                   irq_q
);
  logic [1:0][LREG_W-1:0] len_d;
  logic [1:0][31:0]       cmd_d;
  logic                   gen_d;
  logic                   irq_d;

  always_comb begin
    len_d = len_q;
    cmd_d = cmd_q;
    gen_d = gen_q;
    for (int b = 0; b < 2; b++) begin
      if (wr_len && wr_bank == b[0]) len_d[b] = wdata[LREG_W-1:0];
      if (wr_cmd && wr_bank == b[0]) begin
        cmd_d[b][31:2] = wdata[31:2];
        if (!cmd_q[b][CMD_GO]) begin
          cmd_d[b][CMD_GO]   = wdata[CMD_GO];
          cmd_d[b][CMD_PROG] = wdata[CMD_GO] & wdata[CMD_PROG];
        end
      end
      if (done && done_bank == b[0]) cmd_d[b][1:0] = 2'b00;
    end
    if (wr_gen) gen_d = wdata[GEN_BIT];
    irq_d = done & cmd_q[done_bank][CMD_IE] & gen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cmd_q <= '0;
      gen_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      len_q <= len_d;
      cmd_q <= cmd_d;
      gen_q <= gen_d;
      irq_q <= irq_d;
    end
  end

  // R9
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(gen_q));

  // R5
  go0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[0][CMD_GO]) |-> $past(done && done_bank == 1'b0));

  // R5
  go1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[1][CMD_GO]) |-> $past(done && done_bank == 1'b1));
endmodule

// File: rtl/txbank_engine.sv
module txbank_engine
  import txbank_pkg::*;
#(
  parameter int unsigned BANK_WORDS = 512,
  parameter int unsigned AW         = $clog2(2 * BANK_WORDS),
  parameter int unsigned CNT_W      = $clog2(BANK_WORDS * 4)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             req,
  input  logic [1:0]             prog,
  input  logic [1:0][LREG_W-1:0] len,
  output logic                   mem_re,
  output logic [AW-1:0]          mem_addr,
  input  logic [31:0]            mem_q,
  output logic                   tvalid,
  input  logic                   tready,
  output logic [7:0]             tdata,
  output logic                   tlast,
  output logic                   done,
  output logic                   done_bank,
  output logic [47:0]            station_q
);
  localparam int unsigned MAX_BYTES = (BANK_WORDS - 3) * 4;
  localparam int unsigned WIDX_W    = CNT_W - 2;

  eng_state_t       state_q, state_d;
  logic             bank_q, bank_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [31:0]      lo_q, lo_d;
  logic [47:0]      station_d;
  logic             sel;
  logic [CNT_W-1:0] sel_len;

  always_comb begin
    sel = req[0] ? 1'b0 : 1'b1;
    if (len[sel] > LREG_W'(MAX_BYTES)) sel_len = CNT_W'(MAX_BYTES);
    else                               sel_len = len[sel][CNT_W-1:0];
  end

  always_comb begin
    state_d   = state_q;
    bank_d    = bank_q;
    cnt_d     = cnt_q;
    total_d   = total_q;
    lo_d      = lo_q;
    station_d = station_q;
    mem_re    = 1'b0;
    mem_addr  = {bank_q, cnt_q[CNT_W-1:2]};
    tvalid    = 1'b0;
    tdata     = mem_q[8*cnt_q[1:0] +: 8];
    tlast     = (cnt_q == total_q - 1'b1);
    done      = 1'b0;
    done_bank = bank_q;
    unique case (state_q)
      ENG_IDLE: begin
        if (|req) begin
          bank_d  = sel;
          cnt_d   = '0;
          total_d = sel_len;
          if (prog[sel])         state_d = ENG_PA0;
          else if (sel_len == 0) state_d = ENG_FIN;
          else                   state_d = ENG_FETCH;
        end
      end
      ENG_FETCH: begin
        mem_re  = 1'b1;
        state_d = ENG_SEND;
      end
      ENG_SEND: begin
        tvalid = 1'b1;
        if (tready) begin
          if (tlast) state_d = ENG_FIN;
          else begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q[1:0] == 2'd3) state_d = ENG_FETCH;
          end
        end
      end
      ENG_PA0: begin
        mem_re   = 1'b1;
        mem_addr = {bank_q, WIDX_W'(0)};
        state_d  = ENG_PA1;
      end
      ENG_PA1: begin
        mem_re   = 1'b1;
        mem_addr = {bank_q, WIDX_W'(1)};
        lo_d     = mem_q;
        state_d  = ENG_PA2;
      end
      ENG_PA2: begin
        station_d = {lo_q[7:0], lo_q[15:8], lo_q[23:16], lo_q[31:24],
                     mem_q[7:0], mem_q[15:8]};
        state_d   = ENG_FIN;
      end
      ENG_FIN: begin
        done    = 1'b1;
        state_d = ENG_IDLE;
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ENG_IDLE;
      bank_q    <= 1'b0;
      cnt_q     <= '0;
      total_q   <= '0;
      lo_q      <= '0;
      station_q <= '0;
    end else begin
      state_q   <= state_d;
      bank_q    <= bank_d;
      cnt_q     <= cnt_d;
      total_q   <= total_d;
      lo_q      <= lo_d;
      station_q <= station_d;
    end
  end

  // R11
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> (tvalid && $stable(tdata) && $stable(tlast)));

  // R4
  station_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station_q) |-> $past(state_q == ENG_PA2));

  // R10
  no_bytes_past_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tvalid |-> (cnt_q < total_q));
endmodule

// File: rtl/txbank_ctrl.sv
module txbank_ctrl
  import txbank_pkg::*;
#(
  parameter int unsigned BANK_WORDS = 512,
  parameter int unsigned AW         = $clog2(2 * BANK_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tx_tvalid,
  input  logic          tx_tready,
  output logic [7:0]    tx_tdata,
  output logic          tx_tlast,
  output logic [47:0]   station_addr,
  output logic          irq
);
  localparam int unsigned OFS_W    = AW - 1;
  localparam int unsigned OFS_LEN  = BANK_WORDS - 3;
  localparam int unsigned OFS_GEN  = BANK_WORDS - 2;
  localparam int unsigned OFS_CMD  = BANK_WORDS - 1;

  logic                   a_bank;
  logic [OFS_W-1:0]       a_ofs;
  logic                   is_len, is_gen, is_cmd, is_data;
  logic [1:0][LREG_W-1:0] len_q;
  logic [1:0][31:0]       cmd_q;
  logic                   gen_q;
  logic                   done, done_bank;
  logic                   eng_re;
  logic [AW-1:0]          eng_addr;
  logic [31:0]            bus_q, eng_q;
  logic [1:0]             req, prog;
  logic [31:0]            reg_val;
  logic                   rsel_q, rsel_d;
  logic [31:0]            rval_q, rval_d;

  always_comb begin
    a_bank  = reg_addr[AW-1];
    a_ofs   = reg_addr[OFS_W-1:0];
    is_len  = (a_ofs == OFS_W'(OFS_LEN));
    is_gen  = (a_ofs == OFS_W'(OFS_GEN));
    is_cmd  = (a_ofs == OFS_W'(OFS_CMD));
    is_data = (a_ofs <  OFS_W'(OFS_LEN));
    if (is_len)                 reg_val = 32'(len_q[a_bank]);
    else if (is_cmd)            reg_val = cmd_q[a_bank];
    else if (is_gen && !a_bank) reg_val = {gen_q, 31'b0};
    else                        reg_val = '0;
  end

  generate
    for (genvar b = 0; b < 2; b++) begin : g_req
      assign req[b]  = cmd_q[b][CMD_GO];
      assign prog[b] = cmd_q[b][CMD_PROG];
    end
  endgenerate

  txbank_mem #(.WORDS(2 * BANK_WORDS), .AW(AW)) u_mem (
    .clk    (clk),
    .we     (reg_wr & is_data),
    .waddr  (reg_addr),
    .wdata  (reg_wdata),
    .a_re   (reg_rd & is_data),
    .a_addr (reg_addr),
    .a_q    (bus_q),
    .b_re   (eng_re),
    .b_addr (eng_addr),
    .b_q    (eng_q)
  );

  txbank_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_len    (reg_wr & is_len),
    .wr_gen    (reg_wr & is_gen & ~a_bank),
    .wr_cmd    (reg_wr & is_cmd),
    .wr_bank   (a_bank),
    .wdata     (reg_wdata),
    .done      (done),
    .done_bank (done_bank),
    .len_q     (len_q),
    .cmd_q     (cmd_q),
    .gen_q     (gen_q),
    .irq_q     (irq)
  );

  txbank_engine #(.BANK_WORDS(BANK_WORDS), .AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .prog      (prog),
    .len       (len_q),
    .mem_re    (eng_re),
    .mem_addr  (eng_addr),
    .mem_q     (eng_q),
    .tvalid    (tx_tvalid),
    .tready    (tx_tready),
    .tdata     (tx_tdata),
    .tlast     (tx_tlast),
    .done      (done),
    .done_bank (done_bank),
    .station_q (station_addr)
  );

  always_comb begin
    rsel_d = rsel_q;
    rval_d = rval_q;
    if (reg_rd) begin
      rsel_d = ~is_data;
      rval_d = reg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= 1'b1;
      rval_q <= '0;
    end else begin
      rsel_q <= rsel_d;
      rval_q <= rval_d;
    end
  end

  assign reg_rdata = rsel_q ? rval_q : bus_q;

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tlast && tx_tvalid && tx_tready |=> !tx_tvalid);
endmodule

// File: tb/txbank_ctrl_bench.sv
module txbank_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_tvalid, tx_tlast, irq;
  logic        tx_tready = 1'b1;
  logic [7:0]  tx_tdata;
  logic [47:0] station_addr;

  int checks = 0, errors = 0, irq_cnt = 0, cycles = 0;
  logic irq_prev = 1'b0;
  logic [7:0] got_q[$];
  logic       lst_q[$];

  localparam logic [9:0] LEN0 = 10'h1FD, GEN = 10'h1FE, CMD0 = 10'h1FF;
  localparam logic [9:0] LEN1 = 10'h3FD, CMD1 = 10'h3FF, B1 = 10'h200;

  always #2 clk = ~clk;

  txbank_ctrl u_txbank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
    .tx_tlast(tx_tlast), .station_addr(station_addr), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (tx_tvalid && tx_tready) begin
        got_q.push_back(tx_tdata);
        lst_q.push_back(tx_tlast);
      end
      if (irq) begin
        irq_cnt++;
        if (irq_prev) chk("R9 pulse width", 1, 0);
      end
      irq_prev = irq;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush();
    got_q.delete(); lst_q.delete();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 tvalid", tx_tvalid, 0);
    chk("R1 irq", irq, 0);
    chk("R1 station", station_addr, 0);
    rd(CMD0, v); chk("R1 cmd0", v, 0);
    rd(LEN1, v); chk("R1 len1", v, 0);
    rd(GEN, v);  chk("R1 gen", v, 0);
  endtask

  task automatic t_bufrw();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) wr(10'(i), 32'hC0DE0000 + i);
    wr(B1 + 5, 32'h5A5AA5A5);
    for (int i = 0; i < 4; i++) begin
      rd(10'(i), v); chk("R2 bank0 word", v, 32'hC0DE0000 + i);
    end
    rd(B1 + 5, v); chk("R2 bank1 word", v, 32'h5A5AA5A5);
    wr(LEN0, 32'hABCD1234); rd(LEN0, v); chk("R2 len low16", v, 32'h1234);
    wr(GEN, 32'hFFFFFFFF); rd(GEN, v); chk("R2 gen bit31", v, 32'h80000000);
  endtask

  task automatic t_send();
    logic [31:0] v;
    int base;
    flush(); base = irq_cnt;
    wr(0, 32'h03020100); wr(1, 32'h07060504);
    wr(LEN0, 7); wr(CMD0, 32'h9);
    idle(40);
    chk("R3 byte count", got_q.size(), 7);
    for (int i = 0; i < 7 && i < got_q.size(); i++) begin
      chk("R3 byte order", got_q[i], i);
      chk("R3 last flag", lst_q[i], (i == 6));
    end
    chk("R9 irq on send", irq_cnt - base, 1);
    rd(CMD0, v); chk("R5 cleared after send", v, 32'h8);
  endtask

  task automatic t_prog();
    logic [31:0] v;
    int base;
    flush(); base = irq_cnt;
    wr(B1, 32'h44332211); wr(B1 + 1, 32'h00006655);
    wr(CMD1, 32'h3);
    idle(15);
    chk("R4 station", station_addr, 48'h112233445566);
    chk("R4 no bytes", got_q.size(), 0);
    chk("R9 bank ie off", irq_cnt - base, 0);
    rd(CMD1, v); chk("R5 cleared after prog", v, 0);
  endtask

  task automatic t_stall();
    logic [31:0] v;
    logic [47:0] st;
    int base;
    flush(); base = irq_cnt; st = station_addr;
    tx_tready = 1'b0;
    wr(0, 32'hA3A2A1A0); wr(1, 32'hA7A6A5A4);
    wr(LEN0, 5); wr(CMD0, 32'h1);
    idle(6);
    chk("R11 valid held", tx_tvalid, 1);
    chk("R11 byte held", tx_tdata, 8'hA0);
    rd(CMD0, v); chk("R5 busy bits", v, 32'h1);
    wr(CMD0, 32'h10B);
    rd(CMD0, v); chk("R7 busy write", v, 32'h109);
    wr(B1, 32'hB3B2B1B0); wr(LEN1, 3); wr(CMD1, 32'h1);
    rd(CMD1, v); chk("R8 held start", v, 32'h1);
    chk("R11 byte still held", tx_tdata, 8'hA0);
    chk("R8 nothing sent yet", got_q.size(), 0);
    tx_tready = 1'b1;
    idle(40);
    chk("R8 total bytes", got_q.size(), 8);
    for (int i = 0; i < 8 && i < got_q.size(); i++) begin
      chk("R8 sequence", got_q[i], (i < 5) ? (8'hA0 + i) : (8'hB0 + i - 5));
      chk("R8 last flags", lst_q[i], (i == 4 || i == 7));
    end
    chk("R7 station untouched", station_addr, st);
    chk("R9 bank0 ie updated", irq_cnt - base, 1);
    rd(CMD0, v); chk("R5 bank0 after", v, 32'h108);
  endtask

  task automatic t_nocmd();
    logic [31:0] v;
    int base;
    flush(); base = irq_cnt;
    wr(CMD0, 32'hA);
    idle(20);
    chk("R6 no bytes", got_q.size(), 0);
    chk("R6 no irq", irq_cnt - base, 0);
    rd(CMD0, v); chk("R6 stored", v, 32'h8);
  endtask

  task automatic t_gen();
    int base;
    flush(); base = irq_cnt;
    wr(GEN, 0); wr(LEN0, 1); wr(CMD0, 32'h9);
    idle(20);
    chk("R9 gen off no irq", irq_cnt - base, 0);
    chk("R9 byte still sent", got_q.size(), 1);
    wr(GEN, 32'h80000000); wr(CMD0, 32'h9);
    idle(20);
    chk("R9 gen on irq", irq_cnt - base, 1);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int base, lasts;
    flush(); base = irq_cnt;
    wr(LEN0, 0); wr(CMD0, 32'h9);
    idle(10);
    chk("R10 zero length bytes", got_q.size(), 0);
    chk("R10 zero length irq", irq_cnt - base, 1);
    rd(CMD0, v); chk("R10 zero length done", v, 32'h8);
    flush();
    wr(LEN0, 32'hFFFF); wr(CMD0, 32'h1);
    idle(3000);
    chk("R10 clamp count", got_q.size(), 2036);
    lasts = 0;
    foreach (lst_q[i]) if (lst_q[i]) lasts++;
    chk("R10 clamp one last", lasts, 1);
    if (lst_q.size() > 0) chk("R10 clamp last at end", lst_q[lst_q.size()-1], 1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int base;
    flush(); base = irq_cnt;
    wr(0, 32'h000000C1 | 32'h0000C200); wr(LEN0, 2);
    wr(B1, 32'h000000D1); wr(LEN1, 1);
    wr(CMD0, 32'h9);
    do @(negedge clk); while (!(tx_tvalid && tx_tlast && tx_tready));
    wr(CMD1, 32'h9);
    idle(20);
    chk("R8 collide bytes", got_q.size(), 3);
    if (got_q.size() == 3) begin
      chk("R8 collide b0", got_q[0], 8'hC1);
      chk("R8 collide b1", got_q[1], 8'hC2);
      chk("R8 collide b2", got_q[2], 8'hD1);
    end
    chk("R9 collide irqs", irq_cnt - base, 2);
    rd(CMD0, v); chk("R5 collide cmd0", v, 32'h8);
    rd(CMD1, v); chk("R5 collide cmd1", v, 32'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bufrw();
    t_send();
    t_prog();
    t_stall();
    t_nocmd();
    t_gen();
    t_zero();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule